// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single memory requests from a processor core into bus cycles on an external parallel bus. The low address byte and the data byte share one set of pins. The bus has an address strobe, an active-low read strobe, an active-low write strobe and an active-low wait input. Each accepted request is classified as internal or external by comparing its address with a boundary parameter. The block then runs a fixed phase sequence: address, latch, data (possibly stretched by wait) and recovery. At the end it returns a one-cycle done pulse, along with read data for external reads.

The address strobe phase runs on every access, internal ones included, so the cycle timing is the same whatever the target. The read and write strobes move only on external accesses. The wait input is honoured only on external accesses, and only while the wait-enable mode input is high. When that input is low, the wait pin is assumed to serve as a general port.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `astb`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in the idle phase, so a request raised during a cycle is ignored.
- R3: Every access, internal or external, drives `astb` high for exactly one clock, in the cycle that follows acceptance.
- R4: On an external access, `ad_oe`=1 and `ad_out` carries address bits [7:0] during the address cycle and the latch cycle. `addr_hi` carries address bits [15:8].
- R5: An external instruction fetch (`req_fetch`=1) or data read (`req_write`=0) holds `rd_n` low for the whole data phase and keeps `ad_oe`=0 there. `wr_n` stays high. If `req_fetch` and `req_write` are both 1, the access is a read.
- R6: An external data write holds `wr_n` low for the whole data phase and drives `ad_out` with the write data (`ad_oe`=1). `rd_n` stays high.
- R7: An access whose address is below `INT_LIMIT` (default 16'h8000) is internal. `rd_n` and `wr_n` stay high and `ad_oe` stays 0 throughout. Addresses at or above `INT_LIMIT` are external. The class is fixed at acceptance.
- R8: On an external access with `wait_en`=1, each clock edge in the data phase at which `ext_wait_n`=0 adds one more data-phase clock.
- R9: `ext_wait_n` has no effect on internal accesses or when `wait_en`=0. The data phase is then one clock long.
- R10: On an external read, `rdata` takes the value of `ad_in` present in the last data-phase clock. Internal accesses and writes leave `rdata` unchanged.
- R11: `done` is a one-clock pulse in the recovery cycle, which follows the data phase. The access lasts 3 + (data-phase length) clocks after acceptance, and `req_ready` returns to 1 in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = data write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch (forces read) |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| wait_en | input | 1 | 1 = wait input in use |
| ext_wait_n | input | 1 | External wait, active low |
| ad_in | input | 8 | Multiplexed bus input side |
| req_ready | output | 1 | Idle, able to take a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last external read data |
| astb | output | 1 | Address strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Multiplexed address/data output |
| ad_oe | output | 1 | Output enable for `ad_out` |
| addr_hi | output | 8 | High address byte |

## Verification
Directed accesses cover each combination of target (internal, external) and kind (fetch, read, write, fetch with the write bit set). They also cover the two addresses on either side of the boundary, which separates a wrong comparison from a right one. Wait is held low for several clocks with the mode input on and with it off, and on internal accesses as well. This tells honoured stretching apart from ignored wait, and changing the read data each data clock shows which clock is captured. A request raised mid-cycle confirms it is dropped, and a long random run mixes all of these.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_LATCH, PH_DATA, PH_REC
  } phase_t;

  // Classify an address against the internal/external boundary
  function automatic logic addr_is_ext(input logic [31:0] addr, input logic [31:0] limit);
    return addr >= limit;
  endfunction

  // A fetch always reads, whatever the write bit says
  function automatic logic kind_is_write(input logic write, input logic fetch);
    return write & ~fetch;
  endfunction
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_LIMIT = 32'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cyc_ext,
  output logic              cyc_wr,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_ext   <= 1'b0;
      cyc_wr    <= 1'b0;
      cyc_addr  <= '0;
      cyc_wdata <= '0;
    end else if (take) begin
      cyc_ext   <= addr_is_ext(32'(req_addr), 32'(INT_LIMIT));
      cyc_wr    <= kind_is_write(req_write, req_fetch);
      cyc_addr  <= req_addr;
      cyc_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   cyc_ext,
  input  logic   wait_en,
  input  logic   ext_wait_n,
  output phase_t phase,
  output logic   take,
  output logic   ready,
  output logic   data_end,
  output logic   done
);
  phase_t phase_nx;
  logic   stall;

  assign ready    = (phase == PH_IDLE);
  assign take     = req_valid & ready;
  assign stall    = (phase == PH_DATA) & cyc_ext & wait_en & ~ext_wait_n;
  assign data_end = (phase == PH_DATA) & ~stall;
  assign done     = (phase == PH_REC);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:  if (take) phase_nx = PH_ADDR;
      PH_ADDR:  phase_nx = PH_LATCH;
      PH_LATCH: phase_nx = PH_DATA;
      PH_DATA:  if (!stall) phase_nx = PH_REC;
      PH_REC:   phase_nx = PH_IDLE;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  phase_t                   phase,
  input  logic                     data_end,
  input  logic                     cyc_ext,
  input  logic                     cyc_wr,
  input  logic [ADDR_W-1:0]        cyc_addr,
  input  logic [DATA_W-1:0]        cyc_wdata,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     astb,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        rdata
);
  logic addr_ph, data_ph;

  assign addr_ph = (phase == PH_ADDR) | (phase == PH_LATCH);
  assign data_ph = (phase == PH_DATA);

  assign astb    = (phase == PH_ADDR);
  assign rd_n    = ~(data_ph & cyc_ext & ~cyc_wr);
  assign wr_n    = ~(data_ph & cyc_ext & cyc_wr);
  assign ad_oe   = cyc_ext & (addr_ph | (data_ph & cyc_wr));
  assign ad_out  = data_ph ? cyc_wdata : cyc_addr[DATA_W-1:0];
  assign addr_hi = cyc_addr[ADDR_W-1:DATA_W];

  // Capture on the edge that ends the data phase, before the strobe rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            rdata <= '0;
    else if (data_end & cyc_ext & ~cyc_wr) rdata <= ad_in;
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_LIMIT = 32'h8000,
  localparam int HI_W     = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              wait_en,
  input  logic              ext_wait_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              astb,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   addr_hi
);
  phase_t            phase;
  logic              take, data_end;
  logic              cyc_ext, cyc_wr;
  logic [ADDR_W-1:0] cyc_addr;
  logic [DATA_W-1:0] cyc_wdata;
  // Named events for the checker
  logic              busy, in_data;

  assign busy    = (phase != PH_IDLE);
  assign in_data = (phase == PH_DATA);

  xbus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_LIMIT(INT_LIMIT)) u_decode (
    .clk(clk), .rst_n(rst_n), .take(take),
    .req_addr(req_addr), .req_write(req_write), .req_fetch(req_fetch),
    .req_wdata(req_wdata),
    .cyc_ext(cyc_ext), .cyc_wr(cyc_wr), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata)
  );

  xbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cyc_ext(cyc_ext),
    .wait_en(wait_en), .ext_wait_n(ext_wait_n),
    .phase(phase), .take(take), .ready(req_ready), .data_end(data_end), .done(done)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .data_end(data_end),
    .cyc_ext(cyc_ext), .cyc_wr(cyc_wr), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
    .ad_in(ad_in),
    .astb(astb), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_hi(addr_hi), .rdata(rdata)
  );
endmodule

// File: rtl/xbus_chk.sv
module xbus_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic astb,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic wait_en,
  input logic ext_wait_n,
  input logic cyc_ext,
  input logic busy,
  input logic in_data
);
  // R3
  astb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    astb |=> !astb);

  // R2
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> astb);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7
  internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_ext) |-> (rd_n && wr_n && !ad_oe));

  // R7
  class_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cyc_ext));

  // R8
  wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && cyc_ext && wait_en && !ext_wait_n) |=> in_data);

  // R9
  wait_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && (!cyc_ext || !wait_en)) |=> (!in_data && done));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
endmodule

bind xbus_ctrl xbus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .astb(astb), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
  .wait_en(wait_en), .ext_wait_n(ext_wait_n), .cyc_ext(cyc_ext),
  .busy(busy), .in_data(in_data)
);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
  localparam int LIMIT = 32'h8000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_fetch = 0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_in = '0;
  logic        wait_en = 0, ext_wait_n = 1;
  logic        req_ready, done, astb, rd_n, wr_n, ad_oe;
  logic [7:0]  rdata, ad_out, addr_hi;

  int checks = 0, fails = 0;
  logic [7:0] exp_rdata = '0;

  always #5 clk = ~clk;

  xbus_ctrl u_xbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_fetch(req_fetch), .req_addr(req_addr), .req_wdata(req_wdata),
    .wait_en(wait_en), .ext_wait_n(ext_wait_n), .ad_in(ad_in),
    .req_ready(req_ready), .done(done), .rdata(rdata), .astb(astb),
    .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi)
  );

  function automatic bit exp_ext(input logic [15:0] a);
    return int'(a) >= LIMIT;
  endfunction

  function automatic int exp_data_len(input bit ext, input bit wen, input int nwait);
    return (ext && wen) ? nwait + 1 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit fe, input logic [15:0] addr,
                        input logic [7:0] wd, input bit wen, input int nwait, input bit noise);
    bit ext, rd;
    int dlen, k, astb_cnt, rd_cnt, wr_cnt, done_k;
    logic [7:0] last_in;
    ext = exp_ext(addr);
    rd = !(wr && !fe);
    dlen = exp_data_len(ext, wen, nwait);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_fetch = fe; req_addr = addr;
    req_wdata = wd; wait_en = wen;
    @(negedge clk);
    req_valid = 0;
    k = 1; astb_cnt = 0; rd_cnt = 0; wr_cnt = 0; done_k = 0; last_in = '0;
    while (done_k == 0 && k < 60) begin
      if (astb) astb_cnt++;
      if (!rd_n) rd_cnt++;
      if (!wr_n) wr_cnt++;
      if (!ext) chk(!ad_oe && rd_n && wr_n, "R7 internal strobes/oe", {rd_n, wr_n, ad_oe}, 3'b110);
      if (k == 1) begin
        chk(astb == 1'b1, "R3 astb in address cycle", astb, 1);
        chk(req_ready == 1'b0, "R2 busy not ready", req_ready, 0);
        if (ext) begin
          chk(ad_oe && ad_out == addr[7:0], "R4 low address byte", ad_out, addr[7:0]);
          chk(addr_hi == addr[15:8], "R4 high address byte", addr_hi, addr[15:8]);
        end
      end
      if (k == 2 && ext) chk(ad_oe && ad_out == addr[7:0] && !astb, "R4 address in latch cycle", ad_out, addr[7:0]);
      if (k == 2 && noise) begin
        req_valid = 1; req_addr = 16'hFFFF; req_write = 0; req_fetch = 0;
      end
      if (k == 3) req_valid = 0;
      if (k >= 3 && k < 3 + dlen + 1) begin
        ext_wait_n = (k - 2 <= nwait) ? 1'b0 : 1'b1;
        ad_in = 8'($urandom);
        if (k < 3 + dlen) last_in = ad_in;
        if (k < 3 + dlen && ext && !rd) chk(ad_oe && ad_out == wd, "R6 write data on bus", ad_out, wd);
        if (k < 3 + dlen && ext && rd) chk(!ad_oe, "R5 bus released in read", ad_oe, 0);
      end
      if (done) done_k = k;
      else @(negedge clk);
      k++;
    end
    ext_wait_n = 1;
    chk(done_k == 3 + dlen, "R11/R8/R9 done timing", done_k, 3 + dlen);
    chk(astb_cnt == 1, "R3 one astb per access", astb_cnt, 1);
    chk(rd_cnt == ((ext && rd) ? dlen : 0), "R5 read strobe length", rd_cnt, (ext && rd) ? dlen : 0);
    chk(wr_cnt == ((ext && !rd) ? dlen : 0), "R6 write strobe length", wr_cnt, (ext && !rd) ? dlen : 0);
    if (ext && rd) exp_rdata = last_in;
    chk(rdata == exp_rdata, "R10 read data", rdata, exp_rdata);
    @(negedge clk);
    chk(!done && req_ready && !astb, "R11 back to idle", {done, req_ready, astb}, 3'b010);
    if (noise) begin
      @(negedge clk);
      chk(!astb && req_ready, "R2 mid-cycle request ignored", astb, 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(req_ready && !astb && rd_n && wr_n && !ad_oe && !done, "R1 reset state",
        {req_ready, astb, rd_n, wr_n, ad_oe, done}, 6'b101100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !astb && rd_n && wr_n, "R1 idle after reset", req_ready, 1);

    access(0, 0, 16'h1234, 8'h00, 1, 3, 0);   // R7 R9 internal read, wait ignored
    access(1, 0, 16'h0042, 8'h5A, 1, 2, 0);   // R7 internal write
    access(0, 0, 16'h9ABC, 8'h00, 0, 0, 0);   // R5 external read
    access(1, 0, 16'hC0DE, 8'hA5, 1, 3, 0);   // R6 R8 write with waits
    access(0, 1, 16'hF00D, 8'h00, 0, 4, 0);   // R9 fetch, wait disabled
    access(1, 1, 16'h8801, 8'h77, 1, 1, 0);   // R5 fetch beats write bit
    access(0, 0, 16'h7FFF, 8'h00, 1, 2, 0);   // R7 last internal address
    access(0, 0, 16'h8000, 8'h00, 1, 2, 0);   // R7 first external address
    access(0, 0, 16'hA000, 8'h00, 1, 5, 1);   // R2 request raised mid-cycle
    access(0, 0, 16'h2000, 8'h00, 1, 0, 0);   // R10 internal keeps rdata

    for (int i = 0; i < 80; i++)
      access(1'($urandom), 1'($urandom), 16'($urandom), 8'($urandom),
             1'($urandom), int'($urandom % 4), ($urandom % 8) == 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule